// File: doc/BRIEF.md
# Modulo Up/Down Counter with Clock and Count Enables

This block is a synchronous binary counter whose width, modulus and preset constant are parameters. A direction input picks incrementing or decrementing, and the count wraps at the modulus boundary in both directions. The modulus does not have to be a power of two.

Besides counting, the block has four other controls:
- an asynchronous clear that forces zero;
- an active-low synchronous preset that loads a fixed constant;
- a synchronous parallel load from a data bus, which reduces out-of-range values modulo the modulus;
- a terminal-count flag that marks the wrap point for the current direction.

Two enables gate the synchronous behaviour. The clock enable freezes every synchronous action. The count enable stops only the counting, so preset and load still work while it is low.

The default build is a 6-bit modulo-50 counter with a preset of 42 (0x2A). Setting the modulus equal to two to the power of the width gives a free-running build, for example 8 bits with 256 states. All controls are plain level signals sampled on the rising clock edge. There is no streaming data path, so no valid/ready handshake applies.

Top module: `modctr_top`

## Requirements
- R1: With clk_en=1, cnt_en=1, set_n=1, load=0 and dir_up=1, each rising edge raises count by one.
- R2: Under the same enables with dir_up=0, each rising edge lowers count by one.
- R3: Counting up from MODULUS-1 (49) gives 0. Counting down from 0 gives MODULUS-1 (49).
- R4: When set_n=0 and clk_en=1, the next rising edge sets count to PRESET (42). count does not change before that edge.
- R5: When load=1 and clk_en=1, the next rising edge copies load_data into count. Asserting load changes nothing before that edge.
- R6: A loaded value of MODULUS or more is stored as load_data mod MODULUS. For example, 55 gives 5 and 63 gives 13.
- R7: clr=1 forces count to 0 at once, without a clock edge. While clr stays high it overrides set, load and count.
- R8: While clk_en=0, count holds through edges, even when counting, set_n=0 or load=1 is requested.
- R9: While clk_en=1 and cnt_en=0, counting stops, but load and set_n still act.
- R10: Priority among the synchronous actions is preset (set_n=0), then load, then counting.
- R11: term_cnt is 1 exactly when count is MODULUS-1 with dir_up=1, or when count is 0 with dir_up=0.
- R12: count never reaches or exceeds MODULUS.
- R13: A build with WIDTH=8 and MODULUS=256 counts through all 256 values in order and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear to zero, active high |
| clk_en | input | 1 | Clock enable; low freezes every synchronous action |
| cnt_en | input | 1 | Count enable; low stops counting only |
| dir_up | input | 1 | 1 = increment, 0 = decrement |
| set_n | input | 1 | Active-low synchronous preset to PRESET |
| load | input | 1 | Synchronous parallel load request |
| load_data | input | WIDTH | Value to load, reduced modulo MODULUS |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | Count sits at the wrap point for the current direction |

## Verification
The hardest situation to reach from the ports is the count sitting at a wrap boundary while the direction flips, so that term_cnt must move between 49 and 0 with no clock edge in between. Walking there by counting alone takes up to 49 edges. The stimulus instead uses the synchronous load to place the count at 49, checks the flag, counts through the wrap, then reverses the direction at 0 and counts back. Out-of-range loads (55 and 63) use the same load path to reach values that counting can never produce.

// File: rtl/modctr_pkg.sv
package modctr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_PRESET,
    OP_LOAD,
    OP_UP,
    OP_DOWN
  } ctr_op_e;
endpackage

// File: rtl/modctr_op_decode.sv
module modctr_op_decode
  import modctr_pkg::*;
(
  input  logic    clk_en,
  input  logic    cnt_en,
  input  logic    set_n,
  input  logic    load,
  input  logic    dir_up,
  output ctr_op_e op
);
  // Synchronous priority: preset, then load, then counting.
  always_comb begin
    op = OP_HOLD;
    if (clk_en) begin
      if (!set_n)      op = OP_PRESET;
      else if (load)   op = OP_LOAD;
      else if (cnt_en) op = dir_up ? OP_UP : OP_DOWN;
    end
  end
endmodule

// File: rtl/modctr_next_value.sv
module modctr_next_value
  import modctr_pkg::*;
#(
  parameter int WIDTH   = 6,
  parameter int MODULUS = 50,
  parameter int PRESET  = 42
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] nxt
);
  localparam bit             FULL_RANGE = (MODULUS == (1 << WIDTH));
  localparam logic [WIDTH-1:0] TOP      = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] PRE_V    = WIDTH'(PRESET % MODULUS);
  localparam logic [WIDTH:0]   MOD_EXT  = (WIDTH+1)'(MODULUS);

  logic [WIDTH-1:0] inc_v, dec_v, ld_v;

  generate
    if (FULL_RANGE) begin : g_free
      assign inc_v = cur + 1'b1;
      assign dec_v = cur - 1'b1;
      assign ld_v  = load_data;
    end else begin : g_mod
      assign inc_v = (cur >= TOP) ? '0 : cur + 1'b1;
      assign dec_v = (cur == '0) ? TOP : cur - 1'b1;
      assign ld_v  = WIDTH'({1'b0, load_data} % MOD_EXT);
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_PRESET: nxt = PRE_V;
      OP_LOAD:   nxt = ld_v;
      OP_UP:     nxt = inc_v;
      OP_DOWN:   nxt = dec_v;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/modctr_terminal.sv
module modctr_terminal #(
  parameter int WIDTH   = 6,
  parameter int MODULUS = 50
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_up,
  output logic             term
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  assign term = dir_up ? (cur == TOP) : (cur == '0);
endmodule

// File: rtl/modctr_top.sv
module modctr_top
  import modctr_pkg::*;
#(
  parameter int WIDTH   = 6,
  parameter int MODULUS = 50,
  parameter int PRESET  = 42
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             clk_en,
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic             set_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);
  ctr_op_e          op;
  logic [WIDTH-1:0] cnt_q, cnt_d;

  modctr_op_decode u_dec (
    .clk_en (clk_en),
    .cnt_en (cnt_en),
    .set_n  (set_n),
    .load   (load),
    .dir_up (dir_up),
    .op     (op)
  );

  modctr_next_value #(.WIDTH(WIDTH), .MODULUS(MODULUS), .PRESET(PRESET)) u_nxt (
    .op        (op),
    .cur       (cnt_q),
    .load_data (load_data),
    .nxt       (cnt_d)
  );

  always_ff @(posedge clk or posedge clr) begin
    if (clr) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  modctr_terminal #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_term (
    .cur    (cnt_q),
    .dir_up (dir_up),
    .term   (term_cnt)
  );

  assign count = cnt_q;
endmodule

// File: rtl/modctr_chk.sv
module modctr_chk #(
  parameter int WIDTH   = 6,
  parameter int MODULUS = 50,
  parameter int PRESET  = 42
) (
  input logic             clk,
  input logic             clr,
  input logic             clk_en,
  input logic             cnt_en,
  input logic             dir_up,
  input logic             set_n,
  input logic             load,
  input logic [WIDTH-1:0] load_data,
  input logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP   = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] PRE_V = WIDTH'(PRESET % MODULUS);
  localparam logic [WIDTH:0]   M_EXT = (WIDTH+1)'(MODULUS);

  assert_clear_zero_R7: assert property (@(posedge clk) clr |-> count == '0);

  assert_frozen_R8: assert property (@(posedge clk) disable iff (clr)
    !clk_en |=> $stable(count));

  assert_preset_R4: assert property (@(posedge clk) disable iff (clr)
    (clk_en && !set_n) |=> count == PRE_V);

  assert_load_R6: assert property (@(posedge clk) disable iff (clr)
    (clk_en && set_n && load) |=> count == WIDTH'({1'b0, $past(load_data)} % M_EXT));

  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (clr)
    (clk_en && set_n && !load && cnt_en && dir_up && count == TOP) |=> count == '0);

  assert_wrap_down_R3: assert property (@(posedge clk) disable iff (clr)
    (clk_en && set_n && !load && cnt_en && !dir_up && count == '0) |=> count == TOP);

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (clr)
    (clk_en && set_n && !load && !cnt_en) |=> $stable(count));

  assert_in_range_R12: assert property (@(posedge clk) disable iff (clr)
    {1'b0, count} < M_EXT);
endmodule

bind modctr_top modctr_chk #(.WIDTH(WIDTH), .MODULUS(MODULUS), .PRESET(PRESET)) u_chk (
  .clk       (clk),
  .clr       (clr),
  .clk_en    (clk_en),
  .cnt_en    (cnt_en),
  .dir_up    (dir_up),
  .set_n     (set_n),
  .load      (load),
  .load_data (load_data),
  .count     (count)
);

// File: tb/modctr_top_test.sv
module modctr_top_test;
  logic       clk = 1'b0;
  logic       clr, clk_en, cnt_en, dir_up, set_n, load;
  logic [5:0] load_data;
  logic [5:0] count;
  logic       term_cnt;
  logic       clr8;
  logic [7:0] count8;
  logic       term8;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  modctr_top uut (
    .clk(clk), .clr(clr), .clk_en(clk_en), .cnt_en(cnt_en), .dir_up(dir_up),
    .set_n(set_n), .load(load), .load_data(load_data),
    .count(count), .term_cnt(term_cnt)
  );

  modctr_top #(.WIDTH(8), .MODULUS(256), .PRESET(0)) uut_w8 (
    .clk(clk), .clr(clr8), .clk_en(1'b1), .cnt_en(1'b1), .dir_up(1'b1),
    .set_n(1'b1), .load(1'b0), .load_data(8'h00),
    .count(count8), .term_cnt(term8)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    clk_en = 1'b1; cnt_en = 1'b0; set_n = 1'b1; load = 1'b0;
  endtask

  task automatic do_load(input int v);
    idle(); load = 1'b1; load_data = 6'(v);
    tick();
    load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 reset count", count, 0);
    chk("R11 reset term up", term_cnt, 0);
  endtask

  task automatic t_count_up();
    idle(); cnt_en = 1'b1; dir_up = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R1 up", count, i);
    end
  endtask

  task automatic t_count_down();
    idle(); cnt_en = 1'b1; dir_up = 1'b0;
    for (int i = 4; i >= 2; i--) begin
      tick();
      chk("R2 down", count, i);
    end
  endtask

  task automatic t_wrap();
    dir_up = 1'b1;
    do_load(49);
    chk("R11 term at 49 up", term_cnt, 1);
    cnt_en = 1'b1;
    tick();
    chk("R3 up wrap", count, 0);
    chk("R11 term at 0 up", term_cnt, 0);
    dir_up = 1'b0;
    #1;
    chk("R11 term at 0 down", term_cnt, 1);
    tick();
    chk("R3 down wrap", count, 49);
    chk("R11 term at 49 down", term_cnt, 0);
  endtask

  task automatic t_preset();
    idle(); set_n = 1'b0;
    #1;
    chk("R4 before edge", count, 49);
    tick();
    chk("R4 preset", count, 42);
    set_n = 1'b1;
  endtask

  task automatic t_load();
    idle(); load = 1'b1; load_data = 6'd17;
    #1;
    chk("R5 before edge", count, 42);
    tick();
    chk("R5 load", count, 17);
    do_load(55);
    chk("R6 load 55", count, 5);
    do_load(63);
    chk("R6 load 63", count, 13);
  endtask

  task automatic t_clk_en();
    idle(); clk_en = 1'b0; cnt_en = 1'b1; dir_up = 1'b1;
    tick(); tick();
    chk("R8 count frozen", count, 13);
    set_n = 1'b0;
    tick();
    chk("R8 set frozen", count, 13);
    set_n = 1'b1; load = 1'b1; load_data = 6'd30;
    tick();
    chk("R8 load frozen", count, 13);
    idle();
  endtask

  task automatic t_cnt_en();
    idle(); dir_up = 1'b1;
    tick(); tick();
    chk("R9 no count", count, 13);
    do_load(30);
    chk("R9 load acts", count, 30);
    set_n = 1'b0;
    tick();
    chk("R9 set acts", count, 42);
    set_n = 1'b1;
  endtask

  task automatic t_priority();
    idle(); set_n = 1'b0; load = 1'b1; load_data = 6'd7; cnt_en = 1'b1;
    do_load(20);
    set_n = 1'b0; load = 1'b1; load_data = 6'd7; cnt_en = 1'b1;
    tick();
    chk("R10 set over load", count, 42);
    set_n = 1'b1;
    tick();
    chk("R10 load over count", count, 7);
    idle();
  endtask

  task automatic t_range();
    int bad = 0;
    int maxv = 0;
    idle(); cnt_en = 1'b1; dir_up = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (count >= 50) bad++;
      if (int'(count) > maxv) maxv = count;
    end
    chk("R12 out of range samples", bad, 0);
    chk("R12 max seen", maxv, 49);
    idle();
  endtask

  task automatic t_async_clear();
    do_load(33);
    @(negedge clk);
    clr = 1'b1;
    #1;
    chk("R7 async clear", count, 0);
    set_n = 1'b0; load = 1'b1; load_data = 6'd9;
    tick();
    chk("R7 clear overrides", count, 0);
    idle();
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_wide();
    int bad = 0;
    @(negedge clk);
    clr8 = 1'b0;
    for (int i = 1; i <= 256; i++) begin
      tick();
      if (int'(count8) != (i % 256)) bad++;
    end
    chk("R13 8-bit sequence mismatches", bad, 0);
    chk("R13 back to zero", count8, 0);
  endtask

  initial begin
    #(2_000_000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr = 1'b1; clr8 = 1'b1;
    clk_en = 1'b1; cnt_en = 1'b0; dir_up = 1'b1;
    set_n = 1'b1; load = 1'b0; load_data = '0;
    #1;
    t_reset();
    @(posedge clk); #2;
    clr = 1'b0;
    t_count_up();
    t_count_down();
    t_wrap();
    t_preset();
    t_load();
    t_clk_en();
    t_cnt_en();
    t_priority();
    t_range();
    t_async_clear();
    t_wide();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule